// File: doc/BRIEF.md
# Byte-strobe CPU bus decoder

This block sits between a 16-bit-data CPU core with a 24-bit byte address space and the memories and peripherals of an arcade main board. The CPU presents a word address together with separate strobes for the upper and lower byte lanes, an address strobe, a read/write line and a cycle-type code. The decoder turns each bus cycle into one chip select, answers reads with data, and acknowledges every cycle so the CPU never waits forever. Decoding happens only while the CPU owns the bus.

Program ROM lives off-chip behind a word-wide port with a request/data-valid handshake. Work RAM is on-chip and built from two byte-wide banks, so that byte writes touch only the addressed lane. Everything above the RAM window is routed to one of three peripheral selects (I/O, sound shared area, video). The block also holds a vertical-blank interrupt, shown on the highest-weight interrupt level input, until the CPU runs an interrupt-acknowledge cycle.

Top module: `cpu_bus_decode`

## Requirements
- R1: A cycle is decoded only while `cpu_astb_n` is 0 and `ext_own_n` is 1. Otherwise every select, `rom_req` and the acknowledge stay inactive, and RAM is not written.
- R2: Byte address 0x000000..0x0FFFFF (byte address = {cpu_wa, 0}) asserts `sel_rom`. A read there drives `rom_req` high until acknowledged, and `rom_addr` carries cpu_wa[19:1]. A write there issues no request and is acknowledged one clock after decode.
- R3: A ROM read is acknowledged (`cpu_ack_n` low) on the clock edge after `rom_ok` is sampled high with the request pending. `cpu_rdata` then shows the `rom_data` sampled at that edge.
- R4: Byte address 0x100000..0x10FFFF asserts `sel_ram`. Storage holds 2^RAM_AW words indexed by cpu_wa[RAM_AW:1], so higher addresses in the window alias.
- R5: A RAM write with `cpu_hi_stb_n` low stores `cpu_wdata[15:8]` in the upper bank. With `cpu_lo_stb_n` low it stores `cpu_wdata[7:0]` in the lower bank. Both low is a word write. A lane whose strobe is high keeps its old byte.
- R6: A RAM access is acknowledged one clock after decode. A RAM read returns {upper bank, lower bank} as one word, whichever strobes are low.
- R7: Other addresses assert exactly one bit of `sel_periph`: bit 2 (video) when byte address bit 23 is 1, bit 1 (sound) when bit 23 is 0 and bit 22 is 1, and bit 0 (I/O) otherwise. Reads return 16'hFFFF, and the cycle is acknowledged one clock after decode.
- R8: `cpu_ack_n` goes high in the same cycle that `cpu_astb_n` goes high. It stays low while the cycle lasts and is asserted again only for a new cycle.
- R9: A rising edge of `vblank` sets a pending interrupt. `cpu_irq_n` is {~pending, 1, 1}, so bit 2 (the highest weight) carries it and bits 1:0 stay high.
- R10: An acknowledge cycle is `cpu_ctype` = 3'b111 with `cpu_astb_n` low. Its first clock edge clears the pending interrupt. If a `vblank` rising edge is sampled at that same edge, the interrupt stays pending.
- R11: Synchronous active-high reset releases the acknowledge, clears the pending interrupt and makes `cpu_rdata` 16'hFFFF, even while a cycle is on the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cpu_wa | input | 23 | CPU word address, bits 23:1 |
| cpu_astb_n | input | 1 | Address strobe, active low |
| cpu_hi_stb_n | input | 1 | Upper byte lane strobe, active low |
| cpu_lo_stb_n | input | 1 | Lower byte lane strobe, active low |
| cpu_read | input | 1 | 1 = read cycle, 0 = write cycle |
| ext_own_n | input | 1 | Low while another master owns the bus |
| cpu_ctype | input | 3 | Cycle-type code; 3'b111 marks interrupt acknowledge |
| cpu_wdata | input | 16 | Write data from CPU |
| cpu_rdata | output | 16 | Read data to CPU |
| cpu_ack_n | output | 1 | Data acknowledge, active low |
| cpu_irq_n | output | 3 | Interrupt level inputs of the CPU, active low |
| vblank | input | 1 | Vertical blanking flag from video timing |
| rom_req | output | 1 | ROM word request |
| rom_addr | output | ROM_AW | ROM word address |
| rom_data | input | 16 | ROM word data |
| rom_ok | input | 1 | ROM data valid |
| sel_rom | output | 1 | ROM window select |
| sel_ram | output | 1 | Work RAM window select |
| sel_periph | output | 3 | One-hot peripheral select: 0 I/O, 1 sound, 2 video |

## Verification
The two events that can share one clock edge are a vertical-blank rising edge and the first edge of an interrupt-acknowledge cycle. The bench starts an acknowledge cycle in the same cycle that `vblank` rises, so both are sampled at one edge. It expects the interrupt still to be pending afterwards, and a later acknowledge with no new edge to clear it. A second overlap is a byte write to one lane followed by a read: the untouched lane must survive, and the read must return the full word, whichever strobe the read uses.

// File: rtl/busdec_pkg.sv
package busdec_pkg;

    localparam logic [23:0] ROM_LAST  = 24'h0F_FFFF;
    localparam logic [23:0] RAM_FIRST = 24'h10_0000;
    localparam logic [23:0] RAM_LAST  = 24'h10_FFFF;

    localparam int          PERIPH_N  = 3;
    localparam int          PER_IO    = 0;
    localparam int          PER_SND   = 1;
    localparam int          PER_VID   = 2;

    localparam int          LANES     = 2;
    localparam logic [15:0] OPEN_BUS  = 16'hFFFF;
    localparam logic [2:0]  CT_IACK   = 3'b111;

    typedef enum logic [2:0] {
        RGN_NONE,
        RGN_ROM,
        RGN_RAM,
        RGN_IO,
        RGN_SND,
        RGN_VID
    } region_e;

    // One decoded bus cycle
    typedef struct packed {
        logic             valid;   // CPU owns bus and strobe is low
        logic             rd;      // read cycle
        logic [LANES-1:0] lanes;   // [1] upper byte, [0] lower byte
        region_e          rgn;     // RGN_NONE when not valid
    } bus_req_t;

    function automatic region_e classify(input logic [23:0] ba);
        if (ba <= ROM_LAST)                        return RGN_ROM;
        else if (ba >= RAM_FIRST && ba <= RAM_LAST) return RGN_RAM;
        else if (ba[23])                           return RGN_VID;
        else if (ba[22])                           return RGN_SND;
        else                                       return RGN_IO;
    endfunction

    function automatic region_e periph_region(input int idx);
        case (idx)
            PER_IO:  return RGN_IO;
            PER_SND: return RGN_SND;
            default: return RGN_VID;
        endcase
    endfunction

endpackage

// File: rtl/busdec_map.sv
module busdec_map
    import busdec_pkg::*;
(
    input  logic [23:1] wa,
    input  logic        astb_n,
    input  logic        ext_own_n,
    input  logic        rd,
    input  logic        hi_stb_n,
    input  logic        lo_stb_n,
    output bus_req_t    req
);

    logic [23:0] byte_addr;

    assign byte_addr = {wa, 1'b0};

    always_comb begin
        req.valid = !astb_n && ext_own_n;
        req.rd    = rd;
        req.lanes = {!hi_stb_n, !lo_stb_n};
        req.rgn   = req.valid ? classify(byte_addr) : RGN_NONE;
    end

endmodule

// File: rtl/busdec_wram.sv
module busdec_wram #(
    parameter int AW    = 11,
    parameter int LANES = 2
) (
    input  logic               clk,
    input  logic [LANES-1:0]   we,
    input  logic [AW-1:0]      addr,
    input  logic [LANES*8-1:0] wdata,
    output logic [LANES*8-1:0] rdata
);

    localparam int DEPTH = 1 << AW;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [7:0] bank [DEPTH];
        logic [7:0] q;

        always_ff @(posedge clk) begin
            if (we[g]) begin
                bank[addr] <= wdata[g*8 +: 8];
            end
            q <= bank[addr];
        end

        assign rdata[g*8 +: 8] = q;
    end

endmodule

// File: rtl/busdec_ack.sv
module busdec_ack
    import busdec_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        valid,
    input  logic        rd,
    input  region_e     rgn,
    input  logic        rom_ok,
    input  logic [15:0] rom_data,
    input  logic [15:0] ram_q,
    output logic        rom_req,
    output logic        ack_n,
    output logic [15:0] rdata
);

    logic        ack_q;
    logic [15:0] rom_lat;
    logic        rom_rd;

    assign rom_rd  = (rgn == RGN_ROM) && rd;
    assign rom_req = rom_rd && !ack_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ack_q   <= 1'b0;
            rom_lat <= OPEN_BUS;
        end else if (!valid) begin
            ack_q   <= 1'b0;
        end else if (!ack_q) begin
            if (rom_rd) begin
                if (rom_ok) begin
                    ack_q   <= 1'b1;
                    rom_lat <= rom_data;
                end
            end else begin
                ack_q <= 1'b1;
            end
        end
    end

    // Release follows the strobe without waiting for a clock
    assign ack_n = !(ack_q && valid);

    always_comb begin
        rdata = OPEN_BUS;
        if (ack_q && valid && rd) begin
            case (rgn)
                RGN_ROM: rdata = rom_lat;
                RGN_RAM: rdata = ram_q;
                default: rdata = OPEN_BUS;
            endcase
        end
    end

    AST_ROM_WAITS_DATA: assert property (@(posedge clk) disable iff (rst)
        (rom_rd && !ack_q && !rom_ok) |=> !ack_q); // R3

    AST_ACK_AFTER_DECODE: assert property (@(posedge clk) disable iff (rst)
        (valid && !rom_rd && !ack_q) |=> ack_q); // R6

    AST_IDLE_NO_ACK: assert property (@(posedge clk) disable iff (rst)
        !valid |=> !ack_q); // R8

endmodule

// File: rtl/busdec_irq.sv
module busdec_irq
    import busdec_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       vblank,
    input  logic       astb_n,
    input  logic [2:0] ctype,
    output logic [2:0] irq_n
);

    logic vb_q;
    logic iack_q;
    logic pend_q;
    logic iack;
    logic vb_rise;
    logic iack_start;

    assign iack       = !astb_n && (ctype == CT_IACK);
    assign vb_rise    = vblank && !vb_q;
    assign iack_start = iack && !iack_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            vb_q   <= 1'b0;
            iack_q <= 1'b0;
            pend_q <= 1'b0;
        end else begin
            vb_q   <= vblank;
            iack_q <= iack;
            if (vb_rise) begin
                pend_q <= 1'b1;
            end else if (iack_start) begin
                pend_q <= 1'b0;
            end
        end
    end

    assign irq_n = {!pend_q, 2'b11};

    AST_VBL_SETS: assert property (@(posedge clk) disable iff (rst)
        vb_rise |=> !irq_n[2]); // R9

    AST_NO_SPURIOUS_IRQ: assert property (@(posedge clk) disable iff (rst)
        (!vb_rise && irq_n[2]) |=> irq_n[2]); // R9

    AST_IACK_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (iack_start && !vb_rise) |=> irq_n[2]); // R10

endmodule

// File: rtl/cpu_bus_decode.sv
module cpu_bus_decode
    import busdec_pkg::*;
#(
    parameter int RAM_AW = 11,
    parameter int ROM_AW = 19
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [23:1]         cpu_wa,
    input  logic                cpu_astb_n,
    input  logic                cpu_hi_stb_n,
    input  logic                cpu_lo_stb_n,
    input  logic                cpu_read,
    input  logic                ext_own_n,
    input  logic [2:0]          cpu_ctype,
    input  logic [15:0]         cpu_wdata,
    output logic [15:0]         cpu_rdata,
    output logic                cpu_ack_n,
    output logic [2:0]          cpu_irq_n,
    input  logic                vblank,
    output logic                rom_req,
    output logic [ROM_AW-1:0]   rom_addr,
    input  logic [15:0]         rom_data,
    input  logic                rom_ok,
    output logic                sel_rom,
    output logic                sel_ram,
    output logic [PERIPH_N-1:0] sel_periph
);

    bus_req_t          req;
    logic [LANES-1:0]  ram_we;
    logic [15:0]       ram_q;

    busdec_map u_map (
        .wa        (cpu_wa),
        .astb_n    (cpu_astb_n),
        .ext_own_n (ext_own_n),
        .rd        (cpu_read),
        .hi_stb_n  (cpu_hi_stb_n),
        .lo_stb_n  (cpu_lo_stb_n),
        .req       (req)
    );

    assign sel_rom  = (req.rgn == RGN_ROM);
    assign sel_ram  = (req.rgn == RGN_RAM);
    assign rom_addr = cpu_wa[ROM_AW:1];

    for (genvar p = 0; p < PERIPH_N; p++) begin : g_psel
        assign sel_periph[p] = (req.rgn == periph_region(p));
    end

    for (genvar g = 0; g < LANES; g++) begin : g_we
        assign ram_we[g] = sel_ram && !req.rd && req.lanes[g];
    end

    busdec_wram #(
        .AW    (RAM_AW),
        .LANES (LANES)
    ) u_wram (
        .clk   (clk),
        .we    (ram_we),
        .addr  (cpu_wa[RAM_AW:1]),
        .wdata (cpu_wdata),
        .rdata (ram_q)
    );

    busdec_ack u_ack (
        .clk      (clk),
        .rst      (rst),
        .valid    (req.valid),
        .rd       (req.rd),
        .rgn      (req.rgn),
        .rom_ok   (rom_ok),
        .rom_data (rom_data),
        .ram_q    (ram_q),
        .rom_req  (rom_req),
        .ack_n    (cpu_ack_n),
        .rdata    (cpu_rdata)
    );

    busdec_irq u_irq (
        .clk    (clk),
        .rst    (rst),
        .vblank (vblank),
        .astb_n (cpu_astb_n),
        .ctype  (cpu_ctype),
        .irq_n  (cpu_irq_n)
    );

    AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0({sel_rom, sel_ram, sel_periph})); // R7

    AST_WE_NEEDS_OWNED_WRITE: assert property (@(posedge clk) disable iff (rst)
        (|ram_we) |-> (!cpu_read && !cpu_astb_n && ext_own_n)); // R5

    AST_IDLE_NO_SELECT: assert property (@(posedge clk) disable iff (rst)
        (cpu_astb_n || !ext_own_n) |-> (!sel_rom && !sel_ram && sel_periph == '0 && !rom_req)); // R1

endmodule

// File: tb/sim_cpu_bus_decode.sv
module sim_cpu_bus_decode;

    localparam int RAM_AW = 11;
    localparam int ROM_AW = 19;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [23:1]       wa = '0;
    logic              astb_n = 1'b1, hi_n = 1'b1, lo_n = 1'b1;
    logic              rd = 1'b1, own_n = 1'b1;
    logic [2:0]        ctype = 3'b000;
    logic [15:0]       wdata = '0, rom_data = '0;
    logic              vblank = 1'b0, rom_ok = 1'b0;
    logic [15:0]       rdata;
    logic              ack_n, rom_req, sel_rom, sel_ram;
    logic [2:0]        irq_n, sel_periph;
    logic [ROM_AW-1:0] rom_addr;

    cpu_bus_decode #(.RAM_AW(RAM_AW), .ROM_AW(ROM_AW)) u0 (
        .clk(clk), .rst(rst), .cpu_wa(wa), .cpu_astb_n(astb_n),
        .cpu_hi_stb_n(hi_n), .cpu_lo_stb_n(lo_n), .cpu_read(rd),
        .ext_own_n(own_n), .cpu_ctype(ctype), .cpu_wdata(wdata),
        .cpu_rdata(rdata), .cpu_ack_n(ack_n), .cpu_irq_n(irq_n),
        .vblank(vblank), .rom_req(rom_req), .rom_addr(rom_addr),
        .rom_data(rom_data), .rom_ok(rom_ok), .sel_rom(sel_rom),
        .sel_ram(sel_ram), .sel_periph(sel_periph)
    );

    always #5 clk = ~clk;

    int checks = 0, errors = 0;
    bit finished = 0, started = 0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Region codes: 0 none, 1 ROM, 2 RAM, 3 I/O, 4 sound, 5 video
    function automatic int rgn_of(input logic [23:0] ba);
        if (ba < 24'h100000) return 1;
        if (ba < 24'h110000) return 2;
        if (ba[23])          return 5;
        if (ba[22])          return 4;
        return 3;
    endfunction

    function automatic logic [15:0] rom_pat(input logic [23:1] a);
        return a[16:1] ^ 16'hA55A;
    endfunction

    // Behavioural reference model
    bit          m_ack, m_irq, m_vbp, m_iap, m_hk, m_lk;
    logic [15:0] m_lat = 16'hFFFF, m_ramq = '0;
    logic [7:0]  mh [int];
    logic [7:0]  ml [int];

    always @(posedge clk) begin
        bit v, ia;
        int r, idx;
        v   = !astb_n && own_n;
        r   = v ? rgn_of({wa, 1'b0}) : 0;
        idx = int'(wa[RAM_AW:1]);
        ia  = !astb_n && ctype == 3'b111;
        m_hk = mh.exists(idx);
        m_lk = ml.exists(idx);
        m_ramq = {m_hk ? mh[idx] : 8'h00, m_lk ? ml[idx] : 8'h00};
        if (r == 2 && !rd) begin
            if (!hi_n) mh[idx] = wdata[15:8];
            if (!lo_n) ml[idx] = wdata[7:0];
        end
        if (rst) begin
            m_ack = 0; m_irq = 0; m_vbp = 0; m_iap = 0; m_lat = 16'hFFFF;
        end else begin
            if (vblank && !m_vbp) m_irq = 1;
            else if (ia && !m_iap) m_irq = 0;
            m_vbp = vblank;
            m_iap = ia;
            if (!v) m_ack = 0;
            else if (!m_ack) begin
                if (r == 1 && rd) begin
                    if (rom_ok) begin m_ack = 1; m_lat = rom_data; end
                end else m_ack = 1;
            end
        end
        started = 1;
    end

    // Compare against the model every clock, away from the edge
    always @(posedge clk) begin
        bit v;
        int r;
        string st, dt;
        logic [15:0] ed, mk;
        #3;
        if (started && !finished) begin
            v  = !astb_n && own_n;
            r  = v ? rgn_of({wa, 1'b0}) : 0;
            st = !v ? "R1 select" : (r == 1 ? "R2 select" : (r == 2 ? "R4 select" : "R7 select"));
            dt = !v ? "R8 ack" : (r == 1 ? "R3 ack" : (r == 2 ? "R6 ack" : "R7 ack"));
            chk(sel_rom === (r == 1), st, sel_rom, r == 1);
            chk(sel_ram === (r == 2), st, sel_ram, r == 2);
            chk(sel_periph === {r == 5, r == 4, r == 3}, st, sel_periph, {r == 5, r == 4, r == 3});
            chk(rom_req === (r == 1 && rd && !m_ack), "R2 request", rom_req, r == 1 && rd && !m_ack);
            if (r == 1 && rd) chk(rom_addr === wa[ROM_AW:1], "R2 word address", rom_addr, wa[ROM_AW:1]);
            chk(ack_n === !(m_ack && v), dt, ack_n, !(m_ack && v));
            ed = 16'hFFFF; mk = 16'hFFFF;
            if (m_ack && v && rd) begin
                if (r == 1) ed = m_lat;
                else if (r == 2) begin
                    ed = m_ramq;
                    mk = {m_hk ? 8'hFF : 8'h00, m_lk ? 8'hFF : 8'h00};
                end
            end
            chk((rdata & mk) === (ed & mk), r == 1 ? "R3 data" : (r == 2 ? "R6 data" : "R7 data"), rdata, ed);
            chk(irq_n === {!m_irq, 2'b11}, "R9 irq level", irq_n, {!m_irq, 2'b11});
        end
    end

    task automatic bus(input logic [23:0] ba, input bit rdc, input bit up, input bit lo,
                       input logic [15:0] wd, input int lat, input logic [2:0] ct,
                       input bit vb_now, input string tag, output logic [15:0] got);
        bit acked = 0;
        got = 16'hxxxx;
        @(negedge clk);
        wa = ba[23:1]; rd = rdc; hi_n = !up; lo_n = !lo; wdata = wd; ctype = ct; astb_n = 0;
        if (vb_now) vblank = 1;
        for (int n = 1; n <= 40; n++) begin
            @(posedge clk); #3;
            if (!ack_n) begin acked = 1; got = rdata; break; end
            @(negedge clk);
            if (n == lat) begin rom_ok = 1; rom_data = rom_pat(wa); end
        end
        if (!acked) chk(0, {tag, " no acknowledge"}, 0, 1);
        @(negedge clk);
        astb_n = 1; hi_n = 1; lo_n = 1; rom_ok = 0; ctype = 3'b000; rd = 1;
        #1 chk(ack_n === 1'b1, "R8 release with strobe", ack_n, 1);
    endtask

    initial begin
        logic [15:0] got;
        // R11: reset holds with a cycle on the bus
        @(negedge clk);
        wa = 24'h100040 >> 1; astb_n = 0; rd = 1;
        repeat (2) @(posedge clk);
        #3;
        chk(ack_n === 1'b1, "R11 ack in reset", ack_n, 1);
        chk(irq_n === 3'b111, "R11 irq in reset", irq_n, 3'b111);
        chk(rdata === 16'hFFFF, "R11 data in reset", rdata, 16'hFFFF);
        @(negedge clk); astb_n = 1;
        @(negedge clk); rst = 0;
        repeat (2) @(posedge clk);

        // R6/R5: word write and reads
        bus(24'h100020, 0, 1, 1, 16'h1111, 0, 0, 0, "R6", got);
        bus(24'h100020, 1, 1, 1, 0, 0, 0, 0, "R6", got);
        chk(got === 16'h1111, "R6 word read", got, 16'h1111);

        // R1: cycle while another master owns the bus
        @(negedge clk);
        own_n = 0; wa = 24'h100020 >> 1; rd = 0; hi_n = 0; lo_n = 0; wdata = 16'hDEAD; astb_n = 0;
        for (int i = 0; i < 3; i++) begin
            @(posedge clk); #3;
            chk(!sel_ram && ack_n === 1'b1, "R1 no decode when not owner", {sel_ram, ack_n}, 2'b01);
        end
        @(negedge clk); astb_n = 1; hi_n = 1; lo_n = 1; rd = 1; own_n = 1;
        bus(24'h100020, 1, 1, 1, 0, 0, 0, 0, "R1", got);
        chk(got === 16'h1111, "R1 write ignored", got, 16'h1111);

        // R5: byte lanes
        bus(24'h100010, 0, 1, 1, 16'h1234, 0, 0, 0, "R5", got);
        bus(24'h100010, 0, 1, 0, 16'hAB00, 0, 0, 0, "R5", got);
        bus(24'h100010, 1, 1, 1, 0, 0, 0, 0, "R5", got);
        chk(got === 16'hAB34, "R5 upper lane only", got, 16'hAB34);
        bus(24'h100011, 0, 0, 1, 16'h00CD, 0, 0, 0, "R5", got);
        bus(24'h100010, 1, 1, 0, 0, 0, 0, 0, "R6", got);
        chk(got === 16'hABCD, "R5 lower lane only / R6 full word", got, 16'hABCD);

        // R4: window edges and aliasing
        bus(24'h101000, 0, 1, 1, 16'h7E81, 0, 0, 0, "R4", got);
        bus(24'h100000, 1, 1, 1, 0, 0, 0, 0, "R4", got);
        chk(got === 16'h7E81, "R4 alias", got, 16'h7E81);
        bus(24'h10FFFE, 0, 1, 1, 16'h5AA5, 0, 0, 0, "R4", got);
        bus(24'h10FFFE, 1, 0, 1, 0, 0, 0, 0, "R4", got);
        chk(got === 16'h5AA5, "R4 top of window", got, 16'h5AA5);

        // R2/R3: ROM reads with waits, and a ROM write
        bus(24'h0FFFFE, 1, 1, 1, 0, 3, 0, 0, "R3", got);
        chk(got === rom_pat(24'h0FFFFE >> 1), "R3 rom data, top", got, rom_pat(24'h0FFFFE >> 1));
        bus(24'h000000, 1, 1, 1, 0, 1, 0, 0, "R3", got);
        chk(got === 16'hA55A, "R3 rom data, base", got, 16'hA55A);
        bus(24'h000100, 0, 1, 1, 16'h9999, 0, 0, 0, "R2", got);

        // R7: peripheral windows
        bus(24'h110000, 1, 1, 1, 0, 0, 0, 0, "R7", got);
        chk(got === 16'hFFFF, "R7 io read", got, 16'hFFFF);
        bus(24'h400000, 1, 1, 1, 0, 0, 0, 0, "R7", got);
        chk(got === 16'hFFFF, "R7 sound read", got, 16'hFFFF);
        bus(24'h800000, 1, 0, 1, 0, 0, 0, 0, "R7", got);
        chk(got === 16'hFFFF, "R7 video read", got, 16'hFFFF);

        // R9/R10: interrupt
        @(negedge clk); vblank = 1;
        @(posedge clk); #3;
        chk(irq_n === 3'b011, "R9 set on vblank", irq_n, 3'b011);
        repeat (3) @(negedge clk);
        vblank = 0;
        bus(24'hFFFFFE, 1, 1, 1, 0, 0, 3'b111, 0, "R10", got);
        chk(irq_n === 3'b111, "R10 cleared by acknowledge", irq_n, 3'b111);
        bus(24'hFFFFFE, 1, 1, 1, 0, 0, 3'b111, 1, "R10", got);
        chk(irq_n === 3'b011, "R10 vblank wins same edge", irq_n, 3'b011);
        @(negedge clk); vblank = 0;
        bus(24'hFFFFFE, 1, 1, 1, 0, 0, 3'b111, 0, "R10", got);
        chk(irq_n === 3'b111, "R10 later acknowledge clears", irq_n, 3'b111);

        repeat (3) @(posedge clk);
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule